// File: doc/BRIEF.md
# Command Sync and Dispatch Controller

This block sits behind the read port of a command FIFO. It decodes the word at the FIFO head into one of four classes: primitive, attribute, no-op, or one of three sync kinds. From that class it drives the handshakes for the pipeline that follows. A primitive takes a fixed number of words. It launches only when all of those words are present. It then yields a one-cycle start pulse and walks a shuffle-state counter across its words. An attribute yields a one-cycle valid strobe.

A sync command brings the pipeline to a stop. While a sync is pending, the read address, the shuffle counter and both strobes hold still. Each sync kind has its own release input. Only the release that matches the pending kind ends the stall, and the first cycle after the stall ends can already dispatch the next command.

The block owns the FIFO read address. The head word and the occupancy are assumed to follow that address combinationally. A registered copy of each dispatched head word is presented downstream, aligned with the strobes.

Top module: `csd_sync_dispatch`

## Requirements
- R1: While reset is low, all outputs are zero (read address, shuffle state, start, attribute valid, sync pending, sync kind, command word), whatever the other inputs do.
- R2: The class comes from the opcode in the top four bits of the head word: 0x0–0x7 primitive, 0x8–0xB attribute, 0xC/0xD/0xE sync of kind 0/1/2, 0xF no-op. A no-op is consumed without any strobe.
- R3: The dispatcher is idle when no sync is pending and the shuffle state is 0. When it is idle, the FIFO is not empty, the head is a primitive and the occupancy is at least PRIM_WORDS, the start output is high for exactly the next cycle.
- R4: A primitive head with an occupancy below PRIM_WORDS raises no start, and it leaves the read address and the shuffle state unchanged.
- R5: After a primitive dispatch, the shuffle state reads 1, 2, …, PRIM_WORDS-1 in consecutive cycles and then 0. The read address advances by PRIM_WORDS in the same cycle that the shuffle state returns to 0.
- R6: The attribute valid output is high for one cycle, the cycle after an attribute is dispatched. It is never high for any other class, while a sync is pending, or when the FIFO was empty.
- R7: A dispatched attribute, sync or no-op advances the read address by one in the following cycle.
- R8: In the cycle after a sync word is dispatched, sync pending is high and the sync kind output shows its kind (0, 1 or 2).
- R9: Sync pending goes low one cycle after the release bit whose index equals the pending kind is high. Dispatch resumes in that same cycle.
- R10: A release bit for a different kind, or any release while no sync is pending, has no effect.
- R11: While sync pending is high, the read address and the shuffle state hold, and neither start nor attribute valid is raised.
- R12: The command word output is a registered copy of the head word, captured at each dispatch and held at all other times.
- R13: Two back-to-back syncs of different kinds are each entered and released in turn. The second sync is pending one cycle after the first is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_word | input | DW | Word at the FIFO head (at rd_addr) |
| fifo_empty | input | 1 | FIFO holds no words |
| fifo_count | input | AW+1 | Number of words in the FIFO |
| sync_release | input | 3 | Per-kind release of a pending sync |
| rd_addr | output | AW | FIFO read address |
| shf_state | output | SW | Shuffle state across the words of a primitive |
| prim_start | output | 1 | One-cycle primitive start pulse |
| attr_valid | output | 1 | One-cycle attribute strobe |
| sync_pending | output | 1 | A sync command stalls the pipeline |
| sync_kind | output | 2 | Kind of the pending or last sync |
| cmd_word | output | DW | Registered copy of the dispatched head word |

## Verification
The hardest case to reach is a release that arrives on the wrong kind, or outside a stall, while a primitive sits half-delivered or a second sync waits right behind the first. Here the stall must hold, the read address must stay still, and the exit timing must be exact. To reach it, the stimulus cycles through all sixteen opcodes with walking-one payloads. Pushes are bursty, so the FIFO fills and then starves primitives, and each release line is pulsed independently at random. A cycle-accurate reference model built from the requirements is compared on every output in every cycle. Directed sequences then pin down the occupancy gate, the wrong-kind release and the back-to-back syncs.

// File: rtl/csd_pkg.sv
package csd_pkg;

    typedef enum logic [1:0] {
        CLS_PRIM = 2'd0,
        CLS_ATTR = 2'd1,
        CLS_SYNC = 2'd2,
        CLS_NOP  = 2'd3
    } cmd_cls_e;

    localparam int OP_W   = 4;
    localparam int N_SYNC = 3;

    typedef logic [1:0] sync_kind_t;

    function automatic cmd_cls_e op_class(input logic [OP_W-1:0] op);
        cmd_cls_e c;
        if (!op[3])                c = CLS_PRIM;
        else if (op[3:2] == 2'b10) c = CLS_ATTR;
        else if (op == 4'hF)       c = CLS_NOP;
        else                       c = CLS_SYNC;
        return c;
    endfunction

    function automatic sync_kind_t op_kind(input logic [OP_W-1:0] op);
        return sync_kind_t'(op[1:0]);
    endfunction

endpackage

// File: rtl/csd_cmd_decode.sv
module csd_cmd_decode
    import csd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] head_i,
    output cmd_cls_e      cls_o,
    output sync_kind_t    kind_o
);
    localparam int OP_LSB = DW - OP_W;

    logic [OP_W-1:0] op;

    always_comb begin
        op     = head_i[OP_LSB +: OP_W];
        cls_o  = op_class(op);
        kind_o = op_kind(op);
    end

endmodule

// File: rtl/csd_sync_track.sv
module csd_sync_track
    import csd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_sync_i,
    input  sync_kind_t        take_kind_i,
    input  logic [N_SYNC-1:0] release_i,
    output logic              pend_o,
    output sync_kind_t        kind_o
);
    typedef struct packed {
        logic       pend;
        sync_kind_t kind;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     rel_hit;

    always_comb begin
        st_d    = st_q;
        rel_hit = 1'b0;
        for (int k = 0; k < N_SYNC; k++) begin
            if (st_q.kind == sync_kind_t'(k) && release_i[k]) rel_hit = 1'b1;
        end
        if (st_q.pend) begin
            if (rel_hit) st_d.pend = 1'b0;
        end else if (take_sync_i) begin
            st_d.pend = 1'b1;
            st_d.kind = take_kind_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign kind_o = st_q.kind;

    // Entry: pending with the dispatched kind one cycle after the take.
    assert_sync_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_sync_i |=> (pend_o && kind_o == $past(take_kind_i)));

    // A take must never arrive while a stall is already in force.
    assert_no_take_while_pend_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take_sync_i |-> !pend_o);

    // The matching release ends the stall in exactly one cycle.
    assert_sync_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && release_i[kind_o]) |=> !pend_o);

    // A release of another kind keeps the stall.
    assert_wrong_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !release_i[kind_o]) |=> (pend_o && $stable(kind_o)));

endmodule

// File: rtl/csd_dispatch.sv
module csd_dispatch
    import csd_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 4,
    parameter int PRIM_WORDS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] head_i,
    input  logic          empty_i,
    input  logic [AW:0]   count_i,
    input  cmd_cls_e      cls_i,
    input  logic          sync_pend_i,
    output logic          take_sync_o,
    output logic [AW-1:0] rd_addr_o,
    output logic [(PRIM_WORDS > 2 ? $clog2(PRIM_WORDS) : 1)-1:0] shf_o,
    output logic          start_o,
    output logic          attr_o,
    output logic [DW-1:0] word_o
);
    localparam int            SW       = (PRIM_WORDS > 2) ? $clog2(PRIM_WORDS) : 1;
    localparam logic [SW-1:0] SHF_LAST = SW'(PRIM_WORDS - 1);
    localparam logic [SW-1:0] SHF_ONE  = SW'(1);
    localparam logic [AW-1:0] RD_STEP  = AW'(PRIM_WORDS);
    localparam logic [AW:0]   NEED_OCC = (AW+1)'(PRIM_WORDS);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [SW-1:0] shf;
        logic          start;
        logic          attr;
        logic [DW-1:0] word;
    } disp_st_t;

    disp_st_t st_d, st_q;
    logic     idle, has_head, go_prim, go_one;

    always_comb begin
        idle        = !sync_pend_i && (st_q.shf == '0);
        has_head    = idle && !empty_i;
        go_prim     = has_head && (cls_i == CLS_PRIM) && (count_i >= NEED_OCC);
        go_one      = has_head && (cls_i != CLS_PRIM);
        take_sync_o = go_one && (cls_i == CLS_SYNC);

        st_d       = st_q;
        st_d.start = go_prim;
        st_d.attr  = go_one && (cls_i == CLS_ATTR);

        if (!sync_pend_i) begin
            if (st_q.shf != '0) begin
                if (st_q.shf == SHF_LAST) begin
                    st_d.shf = '0;
                    st_d.rd  = st_q.rd + RD_STEP;
                end else begin
                    st_d.shf = st_q.shf + SHF_ONE;
                end
            end else if (go_prim) begin
                st_d.shf = SHF_ONE;
            end
        end

        if (go_one) st_d.rd = st_q.rd + AW'(1);
        if (go_prim || go_one) st_d.word = head_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_addr_o = st_q.rd;
    assign shf_o     = st_q.shf;
    assign start_o   = st_q.start;
    assign attr_o    = st_q.attr;
    assign word_o    = st_q.word;

    // Start is a single-cycle pulse.
    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // Start coincides with the first step of the shuffle walk.
    assert_start_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (shf_o == SHF_ONE));

    // Shuffle state stays inside the primitive.
    assert_shf_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shf_o <= SHF_LAST);

    // A short primitive never launches.
    assert_short_prim_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !empty_i && cls_i == CLS_PRIM && count_i < NEED_OCC) |=> !start_o);

    // Stall holds pointer and shuffle state and blocks the strobes.
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pend_i |=> ($stable(rd_addr_o) && $stable(shf_o) && !start_o && !attr_o));

    // Attribute strobe never overlaps a stall.
    assert_attr_no_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        attr_o |-> !sync_pend_i);

endmodule

// File: rtl/csd_sync_dispatch.sv
module csd_sync_dispatch
    import csd_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 4,
    parameter int PRIM_WORDS = 4,
    localparam int SW        = (PRIM_WORDS > 2) ? $clog2(PRIM_WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] fifo_word,
    input  logic          fifo_empty,
    input  logic [AW:0]   fifo_count,
    input  logic [2:0]    sync_release,
    output logic [AW-1:0] rd_addr,
    output logic [SW-1:0] shf_state,
    output logic          prim_start,
    output logic          attr_valid,
    output logic          sync_pending,
    output logic [1:0]    sync_kind,
    output logic [DW-1:0] cmd_word
);
    cmd_cls_e   head_cls;
    sync_kind_t head_kind;
    sync_kind_t pend_kind;
    logic       take_sync;

    csd_cmd_decode #(.DW(DW)) u_decode (
        .head_i (fifo_word),
        .cls_o  (head_cls),
        .kind_o (head_kind)
    );

    csd_sync_track u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_sync_i (take_sync),
        .take_kind_i (head_kind),
        .release_i   (sync_release),
        .pend_o      (sync_pending),
        .kind_o      (pend_kind)
    );

    csd_dispatch #(.DW(DW), .AW(AW), .PRIM_WORDS(PRIM_WORDS)) u_disp (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_i      (fifo_word),
        .empty_i     (fifo_empty),
        .count_i     (fifo_count),
        .cls_i       (head_cls),
        .sync_pend_i (sync_pending),
        .take_sync_o (take_sync),
        .rd_addr_o   (rd_addr),
        .shf_o       (shf_state),
        .start_o     (prim_start),
        .attr_o      (attr_valid),
        .word_o      (cmd_word)
    );

    assign sync_kind = pend_kind;

endmodule

// File: tb/csd_sync_dispatch_bench.sv
module csd_sync_dispatch_bench;

    localparam int DW = 32;
    localparam int AW = 4;
    localparam int PW = 4;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] fifo_word;
    logic          fifo_empty;
    logic [AW:0]   fifo_count;
    logic [2:0]    rel = 3'b000;
    logic [AW-1:0] rd_addr;
    logic [1:0]    shf_state;
    logic          prim_start, attr_valid, sync_pending;
    logic [1:0]    sync_kind;
    logic [DW-1:0] cmd_word;

    int wr = 0;
    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    assign fifo_word  = mem[rd_addr];
    assign fifo_count = {1'b0, AW'(wr) - rd_addr};
    assign fifo_empty = (fifo_count == '0);

    csd_sync_dispatch #(.DW(DW), .AW(AW), .PRIM_WORDS(PW)) u_csd_sync_dispatch (
        .clk(clk), .rst_n(rst_n), .fifo_word(fifo_word), .fifo_empty(fifo_empty),
        .fifo_count(fifo_count), .sync_release(rel), .rd_addr(rd_addr),
        .shf_state(shf_state), .prim_start(prim_start), .attr_valid(attr_valid),
        .sync_pending(sync_pending), .sync_kind(sync_kind), .cmd_word(cmd_word)
    );

    // Reference model, built from the requirements.
    int          m_rd = 0;
    int          m_shf = 0;
    logic        m_sync = 1'b0;
    logic [1:0]  m_kind = 2'd0;
    logic        m_start = 1'b0;
    logic        m_attr = 1'b0;
    logic [31:0] m_word = '0;

    always @(posedge clk) begin : model
        int occ_m;
        int op;
        logic [31:0] hw;
        logic idle, go_p, go_1;
        if (!rst_n) begin
            m_rd <= 0; m_shf <= 0; m_sync <= 1'b0; m_kind <= 2'd0;
            m_start <= 1'b0; m_attr <= 1'b0; m_word <= '0;
        end else begin
            occ_m = wr - m_rd;
            hw    = mem[m_rd % DEPTH];
            op    = int'(hw[31:28]);
            idle  = !m_sync && m_shf == 0;
            go_p  = idle && occ_m > 0 && op < 8 && occ_m >= PW;
            go_1  = idle && occ_m > 0 && op >= 8;
            m_start <= go_p;
            m_attr  <= go_1 && op <= 11;
            if (m_sync && rel[m_kind]) m_sync <= 1'b0;
            if (go_1 && op >= 12 && op <= 14) begin
                m_sync <= 1'b1;
                m_kind <= 2'(op - 12);
            end
            if (!m_sync && m_shf != 0) begin
                if (m_shf == PW - 1) begin
                    m_shf <= 0;
                    m_rd  <= m_rd + PW;
                end else begin
                    m_shf <= m_shf + 1;
                end
            end else if (go_p) begin
                m_shf <= 1;
            end
            if (go_1) m_rd <= m_rd + 1;
            if (go_p || go_1) m_word <= hw;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison with the model, away from the active edge.
    always @(negedge clk) begin
        check("R5/R7 rd_addr", 64'(rd_addr), 64'(m_rd % DEPTH));
        check("R5 shf_state", 64'(shf_state), 64'(m_shf));
        check("R3 prim_start", 64'(prim_start), 64'(m_start));
        check("R6 attr_valid", 64'(attr_valid), 64'(m_attr));
        check("R8 sync_pending", 64'(sync_pending), 64'(m_sync));
        check("R8 sync_kind", 64'(sync_kind), 64'(m_kind));
        check("R12 cmd_word", 64'(cmd_word), 64'(m_word));
    end

    task automatic push(input logic [31:0] w);
        mem[wr % DEPTH] = w;
        wr++;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drain();
        rel = 3'b111;
        for (int i = 0; i < 200; i++) begin
            tick();
            if (wr == m_rd && !m_sync && m_shf == 0) break;
        end
        rel = 3'b000;
        tick();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int base;
        int opc;
        logic [31:0] pw;
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;

        // R1: reset holds everything at zero with live inputs.
        push(32'h8000_0011);
        push(32'hD000_0022);
        rel = 3'b111;
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R1 reset outputs", {rd_addr, shf_state, prim_start, attr_valid,
                  sync_pending, sync_kind}, '0);
            check("R1 reset word", 64'(cmd_word), 64'd0);
        end
        rel = 3'b000;
        rst_n = 1'b1;
        tick();
        check("R6 attr after reset", 64'(attr_valid), 64'd1);
        check("R7 rd after attr", 64'(rd_addr), 64'd1);
        tick();
        check("R8 sync kind1 entry", {sync_pending, sync_kind}, {1'b1, 2'd1});
        drain();

        // R4 / R3 / R5: occupancy gate then primitive walk.
        base = m_rd;
        pw = 32'h3ABC_DE01;
        push(pw);
        push(32'h0000_0002);
        for (int i = 0; i < 5; i++) begin
            tick();
            check("R4 no start short", 64'(prim_start), 64'd0);
            check("R4 shf hold", 64'(shf_state), 64'd0);
            check("R4 rd hold", 64'(rd_addr), 64'(base % DEPTH));
        end
        push(32'h0000_0003);
        push(32'h0000_0004);
        tick();
        check("R3 start", 64'(prim_start), 64'd1);
        check("R5 shf=1", 64'(shf_state), 64'd1);
        check("R12 prim word", 64'(cmd_word), 64'(pw));
        tick();
        check("R3 single pulse", 64'(prim_start), 64'd0);
        check("R5 shf=2", 64'(shf_state), 64'd2);
        tick();
        check("R5 shf=3", 64'(shf_state), 64'd3);
        check("R5 rd not yet", 64'(rd_addr), 64'(base % DEPTH));
        tick();
        check("R5 shf back 0", 64'(shf_state), 64'd0);
        check("R5 rd +PW", 64'(rd_addr), 64'((base + PW) % DEPTH));
        drain();

        // R10: release while idle has no effect; R8/R11/R9 stall timing.
        rel = 3'b111;
        tick();
        rel = 3'b000;
        check("R10 idle release", 64'(sync_pending), 64'd0);
        base = m_rd;
        push(32'hE000_0000);
        push(32'h9000_0055);
        tick();
        check("R8 kind2 entry", {sync_pending, sync_kind}, {1'b1, 2'd2});
        check("R7 rd after sync", 64'(rd_addr), 64'((base + 1) % DEPTH));
        rel = 3'b011;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R10 wrong release", 64'(sync_pending), 64'd1);
            check("R11 rd held", 64'(rd_addr), 64'((base + 1) % DEPTH));
            check("R11 no attr", 64'(attr_valid), 64'd0);
        end
        rel = 3'b100;
        tick();
        rel = 3'b000;
        check("R9 exit", 64'(sync_pending), 64'd0);
        check("R9 no early attr", 64'(attr_valid), 64'd0);
        tick();
        check("R9 resume attr", 64'(attr_valid), 64'd1);
        check("R12 attr word", 64'(cmd_word), 64'h9000_0055);
        drain();

        // R13: back-to-back syncs of kinds 0 and 1.
        push(32'hC000_0000);
        push(32'hD000_0000);
        push(32'hF000_0000);
        tick();
        check("R13 first kind0", {sync_pending, sync_kind}, {1'b1, 2'd0});
        rel = 3'b001;
        tick();
        rel = 3'b000;
        check("R13 first released", 64'(sync_pending), 64'd0);
        tick();
        check("R13 second kind1", {sync_pending, sync_kind}, {1'b1, 2'd1});
        rel = 3'b001;
        tick();
        check("R13 kind0 release ignored", 64'(sync_pending), 64'd1);
        rel = 3'b010;
        tick();
        rel = 3'b000;
        check("R13 second released", 64'(sync_pending), 64'd0);
        tick();
        check("R2 nop no strobe", {prim_start, attr_valid}, 2'b00);
        drain();

        // R2: sweep of all opcodes with walking-one payloads, bursty fill and
        // independent random releases; the model checks every cycle.
        opc = 0;
        for (int cyc = 0; cyc < 6000; cyc++) begin
            logic fill;
            tick();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            fill = ((cyc / 400) % 3) == 1;
            if ((fill || lfsr[0]) && (wr - m_rd) < DEPTH - 1) begin
                push({4'(opc % 16), 28'(28'd1 << (opc % 28)) ^ {12'd0, lfsr}});
                opc++;
            end
            rel[0] = (lfsr[3:1] == 3'd0);
            rel[1] = (lfsr[6:4] == 3'd0);
            rel[2] = (lfsr[9:7] == 3'd0);
        end
        rel = 3'b000;
        drain();
        check("R2 sweep drained", 64'(fifo_empty), 64'd1);

        summary();
        $finish;
    end

endmodule